// File: doc/BRIEF.md
# Chainable Stereo Level Serial Control Port

This block is the receive side of a three-wire serial control port for a stereo gain stage. A host lowers the select line, clocks a 16-bit level word into the data pin on rising serial-clock edges, then raises select. The first byte on the wire sets the right channel and the second byte sets the left channel. Both bytes take effect together when select rises. Each code is a level in half-decibel steps. Code 255 is +31.5 dB, code 192 is unity and code 1 is -95.5 dB. Code 0 silences the channel. A separate mute pin silences both channels without changing the stored codes.

While the host shifts a new word in, the serial output carries the word that was held before the transfer, most significant bit first. The host can read the current setting this way. Once those 16 bits are out, the serial output repeats the incoming bits 16 clocks late. Several ports can therefore be chained, each one's output feeding the next one's input, with clock and select shared. A frame longer than 16 bits commits its last 16 bits. A frame shorter than 16 bits is discarded.

All pins are sampled through two-flop synchronisers on the system clock, which must run at least 8 times faster than the serial clock. The block presents registered codes, a mute flag for each channel and a signed gain in half-dB units for each channel.

Top module: `stereo_level_port`

## Requirements
- R1: After reset both codes are 0, both mute flags are 1 and the serial output is 0.
- R2: Data is sampled on serial-clock rising edges while select is low, most significant bit first. The first 8 bits form the right code and the last 8 bits form the left code.
- R3: The codes do not change while select stays low. Both codes update together after select rises.
- R4: A frame with fewer than 16 rising edges leaves both codes unchanged.
- R5: A frame with more than 16 rising edges commits the last 16 bits received.
- R6: From the fall of select, the serial output presents the previously committed word {right, left}, MSB first. It advances one bit after each serial-clock falling edge.
- R7: After the 16 old bits, the serial output delivers each received bit 16 serial-clock periods after it was sampled.
- R8: While select is high the serial output is 0.
- R9: A channel whose code is 0 has its mute flag set. A nonzero code with the mute pin low clears it.
- R10: The mute pin sets both mute flags and leaves the codes unchanged.
- R11: Each gain output is the code minus 192, as a signed 9-bit value (255 gives 63, 192 gives 0, 1 gives -191).
- R12: Serial-clock edges while select is high neither load bits nor shift the readback word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock |
| sdataIn | input | 1 | Serial data in |
| csN | input | 1 | Active-low select, frame boundary |
| muteIn | input | 1 | Mute request for both channels |
| sdataOut | output | 1 | Serial data out (readback / chain) |
| rightCode | output | 8 | Committed right level code |
| leftCode | output | 8 | Committed left level code |
| rightMute | output | 1 | Right channel muted |
| leftMute | output | 1 | Left channel muted |
| rightGain | output | 9 | Right gain in half-dB units, signed |
| leftGain | output | 9 | Left gain in half-dB units, signed |

## Verification
The hardest behaviour to reach from the pins is the pass-through in R7 and R5. It shows only when a frame runs past 16 bits: the output must switch from old stored bits to delayed incoming bits at exactly the seventeenth period, while the commit keeps only the tail of the frame. The stimulus sends a 32-bit frame, as a host driving two chained ports would. The scoreboard expects the old word followed by the first 16 new bits. The bench then checks that the codes hold the second half. A burst of clock edges with select high, followed by an ordinary frame, shows through readback that those edges shifted nothing.

// File: rtl/slp_pkg.sv
package slp_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic sample;      // serial clock rose while selected
    logic shiftOut;    // serial clock fell while selected
    logic frameStart;  // select fell
    logic frameEnd;    // select rose
    logic selActive;   // select currently low (synchronised)
    logic dataBit;     // synchronised serial data
    logic muteReq;     // synchronised mute pin
  } slpStrobes_t;
endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkIn,
  input  logic        sdataIn,
  input  logic        csN,
  input  logic        muteIn,
  output slpStrobes_t strobes
);
  localparam int NUM_IN = 4;
  // bit order inside the sync vector
  localparam int IDX_SCLK = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_CS   = 2;
  localparam int IDX_MUTE = 3;
  localparam logic [NUM_IN-1:0] RESET_VAL = NUM_IN'(1 << IDX_CS);

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncStage [SYNC_STAGES];
  logic [NUM_IN-1:0] synced;
  logic sclkPrev;
  logic csPrev;

  assign rawIn = {muteIn, csN, sdataIn, sclkIn};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= RESET_VAL;
      else if (s == 0) syncStage[s] <= rawIn;
      else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
    end
  end

  assign synced = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= synced[IDX_SCLK];
      csPrev   <= synced[IDX_CS];
    end
  end

  always_comb begin
    strobes.selActive  = ~synced[IDX_CS];
    strobes.sample     = synced[IDX_SCLK] & ~sclkPrev & ~synced[IDX_CS];
    strobes.shiftOut   = ~synced[IDX_SCLK] & sclkPrev & ~synced[IDX_CS];
    strobes.frameStart = ~synced[IDX_CS] & csPrev;
    strobes.frameEnd   = synced[IDX_CS] & ~csPrev;
    strobes.dataBit    = synced[IDX_DATA];
    strobes.muteReq    = synced[IDX_MUTE];
  end
endmodule

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int GAIN_OFFSET = 192
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slpStrobes_t              strobes,
  output logic                     sdataOut,
  output logic [CODE_W-1:0]        rightCode,
  output logic [CODE_W-1:0]        leftCode,
  output logic                     rightMute,
  output logic                     leftMute,
  output logic signed [CODE_W:0]   rightGain,
  output logic signed [CODE_W:0]   leftGain
);
  localparam int WORD_W  = 2 * CODE_W;
  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam int GAIN_W  = CODE_W + 1;
  localparam int NUM_CH  = 2;

  logic [WORD_W-1:0] inShift;
  logic [WORD_W-1:0] readShift;
  logic [WORD_W-1:0] committed;  // {right, left}
  logic [CNT_W-1:0]  bitCount;
  logic              holdBit;
  logic              fullFrame;

  assign fullFrame = (bitCount == CNT_W'(WORD_W));

  // incoming word and saturating bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      bitCount <= '0;
      holdBit  <= 1'b0;
    end else if (strobes.frameStart) begin
      bitCount <= '0;
    end else if (strobes.sample) begin
      inShift <= {inShift[WORD_W-2:0], strobes.dataBit};
      holdBit <= strobes.dataBit;
      if (!fullFrame) bitCount <= bitCount + 1'b1;
    end
  end

  // committed codes, updated only at frame end with a full word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) committed <= '0;
    else if (strobes.frameEnd && fullFrame) committed <= inShift;
  end

  // readback copy: old word first, then the delayed input bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readShift <= '0;
    else if (strobes.frameStart) readShift <= committed;
    else if (strobes.shiftOut) readShift <= {readShift[WORD_W-2:0], holdBit};
  end

  assign sdataOut = strobes.selActive & readShift[WORD_W-1];

  // per-channel decode; channel 0 is right (upper byte), 1 is left
  logic [CODE_W-1:0]        chCode [NUM_CH];
  logic                     chMute [NUM_CH];
  logic signed [GAIN_W-1:0] chGain [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chCode[c] = committed[WORD_W-1-c*CODE_W -: CODE_W];
    assign chMute[c] = strobes.muteReq | (chCode[c] == '0);
    assign chGain[c] = $signed(GAIN_W'(chCode[c])) - $signed(GAIN_W'(GAIN_OFFSET));
  end

  assign rightCode = chCode[0];
  assign leftCode  = chCode[1];
  assign rightMute = chMute[0];
  assign leftMute  = chMute[1];
  assign rightGain = chGain[0];
  assign leftGain  = chGain[1];
endmodule

// File: rtl/stereo_level_port.sv
module stereo_level_port
  import slp_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int GAIN_OFFSET = 192,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclkIn,
  input  logic                   sdataIn,
  input  logic                   csN,
  input  logic                   muteIn,
  output logic                   sdataOut,
  output logic [CODE_W-1:0]      rightCode,
  output logic [CODE_W-1:0]      leftCode,
  output logic                   rightMute,
  output logic                   leftMute,
  output logic signed [CODE_W:0] rightGain,
  output logic signed [CODE_W:0] leftGain
);
  slpStrobes_t strobes;

  slp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .csN(csN), .muteIn(muteIn), .strobes(strobes)
  );

  slp_datapath #(.CODE_W(CODE_W), .GAIN_OFFSET(GAIN_OFFSET)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdataOut(sdataOut),
    .rightCode(rightCode), .leftCode(leftCode),
    .rightMute(rightMute), .leftMute(leftMute),
    .rightGain(rightGain), .leftGain(leftGain)
  );
endmodule

// File: rtl/slp_checker.sv
module slp_checker #(
  parameter int CODE_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclkIn,
  input logic                   sdataIn,
  input logic                   csN,
  input logic                   muteIn,
  input logic                   sdataOut,
  input logic [CODE_W-1:0]      rightCode,
  input logic [CODE_W-1:0]      leftCode,
  input logic                   rightMute,
  input logic                   leftMute,
  input logic signed [CODE_W:0] rightGain,
  input logic signed [CODE_W:0] leftGain
);
  // R8
  idle_output_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !sdataOut);

  // R3
  codes_hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && !$past(csN, 2) && !$past(csN, 3))
      |=> ($stable(rightCode) && $stable(leftCode)));

  // R10
  mute_pin_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (muteIn && $past(muteIn) && $past(muteIn, 2)) |-> (rightMute && leftMute));

  // R10
  mute_keeps_codes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4))
      |=> ($stable(rightCode) && $stable(leftCode)));

  // R9
  zero_code_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rightCode == '0) |-> rightMute) and ((leftCode == '0) |-> leftMute));

  // R11
  unity_gain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftCode == CODE_W'(192)) |-> (leftGain == 0));

  // R11
  top_gain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rightCode == '1) |-> (rightGain == 63));
endmodule

bind stereo_level_port slp_checker #(.CODE_W(CODE_W)) chk (.*);

// File: tb/stereo_level_port_test.sv
module stereo_level_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;          // system clocks per serial-clock half period
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0;
  logic sdataIn = 1'b0;
  logic csN = 1'b1;
  logic muteIn = 1'b0;
  logic sdataOut;
  logic [7:0] rightCode, leftCode;
  logic rightMute, leftMute;
  logic signed [8:0] rightGain, leftGain;

  stereo_level_port uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn), .csN(csN),
    .muteIn(muteIn), .sdataOut(sdataOut), .rightCode(rightCode),
    .leftCode(leftCode), .rightMute(rightMute), .leftMute(leftMute),
    .rightGain(rightGain), .leftGain(leftGain)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] expRight = 8'h00;
  logic [7:0] expLeft  = 8'h00;
  logic expQ [$];
  string tagQ [$];
  event sampleEv;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // scoreboard monitor: compares the serial output at each sampling point
  initial forever begin
    @(sampleEv);
    if (expQ.size() == 0) begin
      check(1'b0, "R6 unexpected sample", int'(sdataOut), -1);
    end else begin
      automatic logic e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      check(sdataOut === e, t, int'(sdataOut), int'(e));
    end
  end

  task automatic checkCodes(input string req);
    check(rightCode === expRight, req, rightCode, expRight);
    check(leftCode === expLeft, req, leftCode, expLeft);
  endtask

  // driver: sends nbits of word (MSB of those first), pushes expected readback
  task automatic sendFrame(input logic [31:0] word, input int nbits);
    automatic logic [15:0] oldWord = {expRight, expLeft};
    for (int i = 0; i < nbits; i++) begin
      if (i < 16) begin
        expQ.push_back(oldWord[15-i]);
        tagQ.push_back("R6 readback");
      end else begin
        expQ.push_back(word[nbits-1-(i-16)]);
        tagQ.push_back("R7 chain pass");
      end
    end
    csN = 1'b0;
    ticks(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdataIn = word[nbits-1-i];
      ticks(HALF/2);
      -> sampleEv;
      ticks(HALF - HALF/2);
      sclkIn = 1'b1;
      ticks(HALF);
      sclkIn = 1'b0;
    end
    ticks(HALF);
    checkCodes("R3 hold while selected");
    csN = 1'b1;
    ticks(8);
    if (nbits >= 16) begin
      expRight = word[15:8];
      expLeft  = word[7:0];
    end
  endtask

  initial begin
    ticks(4);
    rstN = 1'b1;
    ticks(2);
    // R1 reset state
    check(rightCode == 0 && leftCode == 0, "R1 codes", {rightCode, leftCode}, 0);
    check(rightMute && leftMute, "R1 mutes", {rightMute, leftMute}, 3);
    check(sdataOut == 0, "R1 sdataOut", sdataOut, 0);

    // R2 field order, R11 gains, R9 nonzero unmutes
    sendFrame(32'h0000_C0FF, 16);
    checkCodes("R2 field order");
    check(rightGain == 0, "R11 unity", rightGain, 0);
    check(leftGain == 63, "R11 max", leftGain, 63);
    check(!rightMute && !leftMute, "R9 nonzero unmuted", {rightMute, leftMute}, 0);

    // R6 readback of C0FF, R11 low end
    sendFrame(32'h0000_0180, 16);
    checkCodes("R2 second word");
    check(rightGain == -191, "R11 min", rightGain, -191);
    check(leftGain == -64, "R11 mid", leftGain, -64);

    // R4 short frame discarded
    sendFrame(32'h0000_03FF, 10);
    checkCodes("R4 short frame");

    // R12 and R8: clock activity while deselected
    sdataIn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sclkIn = 1'b1; ticks(HALF);
      sclkIn = 1'b0; ticks(HALF);
      check(sdataOut == 0, "R8 idle low", sdataOut, 0);
    end
    checkCodes("R12 codes after idle clocks");
    // readback must still show 0180 (R12 no shift)
    sendFrame(32'h0000_0055, 16);
    checkCodes("R9 zero code load");
    check(rightMute && !leftMute, "R9 zero code mutes", {rightMute, leftMute}, 2);

    // R5/R7 chained frame of 32 bits
    sendFrame(32'h1234_ABCD, 32);
    checkCodes("R5 last 16 bits");
    check(rightCode == 8'hAB, "R5 right", rightCode, 8'hAB);

    // R10 mute pin
    muteIn = 1'b1;
    ticks(4);
    check(rightMute && leftMute, "R10 mute both", {rightMute, leftMute}, 3);
    checkCodes("R10 codes kept");
    muteIn = 1'b0;
    ticks(4);
    check(!rightMute && !leftMute, "R10 release", {rightMute, leftMute}, 0);

    check(expQ.size() == 0, "R6 all samples consumed", expQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule